// File: doc/BRIEF.md
# Asymmetric Tent Map Iterator

This block iterates a piecewise-linear chaotic map on a single fixed-point state in the unit interval. The map has two linear branches that meet at a control point p, which is set to 0.54321. Each step compares the state against p. On the left branch the state is stretched by 1/p. On the right branch the state is folded and stretched by 1/(1-p). The two reciprocals are constants built at elaboration, so a step needs one multiplier and no divider.

A consumer loads a secret initial state through the key port. It then raises the step enable for as many cycles as it needs values. After each step the block presents the new state and a keystream byte cut from the middle of the state, with a valid flag.

Two guards keep the trajectory alive in fixed point. A result of 1.0 or more is clamped to the largest representable fraction. A result of exactly zero is replaced by a small nonzero seed.

Top module: `skt_iter`

## Requirements
- R1: After reset, `state_q` equals the parameter `RESET_STATE` (default 32'h1234_5678) and `ks_valid` is 0.
- R2: A cycle with `key_load` high puts `key_val` in `state_q` at the next edge and leaves `ks_valid` 0, whatever `step_en` is on that cycle.
- R3: On a step where `state_q` is less than or equal to P_Q = round(p·2^32), the next state is bits [61:30] of the 64-bit product `state_q` × R_LO, with R_LO = round(2^30/p). The equality case takes this branch.
- R4: On a step where `state_q` is greater than P_Q, the next state is bits [61:30] of (2^32 − `state_q`) × R_HI, with R_HI = round(2^30/(1−p)).
- R5: When bits [63:62] of the selected product are not both zero, the next state is 32'hFFFF_FFFF.
- R6: When the truncated result is zero, the next state is `ZERO_SEED` (default 1). A state that starts at 0 therefore steps to 1.
- R7: With `key_load` and `step_en` both low, `state_q` holds its value and `ks_valid` is 0.
- R8: `ks_byte` equals bits [23:16] of `state_q`. `ks_valid` is 1 in exactly the cycle after a step taken without a load.
- R9: With `step_en` held high, one new state is produced on every clock edge. Each state is the map applied to the one before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| key_load | input | 1 | Load strobe for the initial state; has priority over stepping |
| key_val | input | STATE_W | Initial state (Q0.32 by default) |
| step_en | input | 1 | Advance the map by one iteration |
| state_q | output | STATE_W | Current state |
| ks_byte | output | 8 | Keystream byte taken from the state |
| ks_valid | output | 1 | The state and byte come from a step |

## Verification
The bench builds two copies of the block. The first uses the default p of 0.54321. Its states on both branches, including the state exactly at P_Q and a long free run, are checked against an integer reference model. The second copy is built with p = 0.5. There the reciprocals are exact powers of two, so a state of one half gives a product of exactly 2^62. That makes the saturation path certain to be hit, and its folded-branch results can be worked out by hand. Both copies start from a zero state to reach the zero-replacement guard.

// File: rtl/skt_pkg.sv
package skt_pkg;
   typedef enum logic {
      BR_STRETCH = 1'b0,
      BR_FOLD    = 1'b1
   } skt_branch_e;

   // round a real to the nearest integer at elaboration
   function automatic longint skt_round(real v);
      return longint'(v);
   endfunction
endpackage

// File: rtl/skt_branch.sv
module skt_branch
   import skt_pkg::*;
#(
   parameter int              STATE_W = 32,
   parameter logic [STATE_W-1:0] P_Q  = '0
) (
   input  logic [STATE_W-1:0] cur,
   output skt_branch_e        br,
   output logic [STATE_W-1:0] operand
);
   always_comb begin
      if (cur <= P_Q) begin
         br      = BR_STRETCH;
         operand = cur;
      end else begin
         br      = BR_FOLD;
         // 1.0 - cur in unsigned fraction: two's complement of cur
         operand = STATE_W'(0) - cur;
      end
   end
endmodule

// File: rtl/skt_scale.sv
module skt_scale #(
   parameter int              STATE_W = 32,
   parameter int              FRAC_R  = 30,
   parameter logic [STATE_W-1:0] ZERO_SEED = 1
) (
   input  logic [STATE_W-1:0]  operand,
   input  logic [FRAC_R+1:0]   recip,
   output logic [STATE_W-1:0]  result
);
   localparam int RW = FRAC_R + 2;
   localparam int PW = STATE_W + RW;

   logic [PW-1:0]      prod;
   logic               ovf;
   logic [STATE_W-1:0] trunc;

   always_comb begin
      prod  = PW'(operand) * PW'(recip);
      ovf   = |prod[PW-1:FRAC_R+STATE_W];
      trunc = prod[FRAC_R +: STATE_W];
      if (ovf)
         result = '1;
      else if (trunc == '0)
         result = ZERO_SEED;
      else
         result = trunc;
   end
endmodule

// File: rtl/skt_iter.sv
module skt_iter
   import skt_pkg::*;
#(
   parameter int              STATE_W     = 32,
   parameter int              FRAC_R      = 30,
   parameter int              KS_LSB      = 16,
   parameter real             P_CTRL      = 0.54321,
   parameter logic [STATE_W-1:0] RESET_STATE = 32'h1234_5678,
   parameter logic [STATE_W-1:0] ZERO_SEED   = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               key_load,
   input  logic [STATE_W-1:0] key_val,
   input  logic               step_en,
   output logic [STATE_W-1:0] state_q,
   output logic [7:0]         ks_byte,
   output logic               ks_valid
);
   localparam int RW = FRAC_R + 2;
   localparam logic [STATE_W-1:0] P_Q =
      STATE_W'(skt_round(P_CTRL * (2.0 ** STATE_W)));
   localparam logic [RW-1:0] R_LO =
      RW'(skt_round((2.0 ** FRAC_R) / P_CTRL));
   localparam logic [RW-1:0] R_HI =
      RW'(skt_round((2.0 ** FRAC_R) / (1.0 - P_CTRL)));

   // elaboration-time parameter checks
   generate
      if (STATE_W < 16 || STATE_W > 48)
         $error("skt_iter: STATE_W must lie in 16..48");
      if (KS_LSB < 0 || KS_LSB + 8 > STATE_W)
         $error("skt_iter: keystream byte falls outside the state");
      if (FRAC_R < 8 || FRAC_R > 40)
         $error("skt_iter: FRAC_R out of range");
      if (P_CTRL <= 0.0 || P_CTRL >= 1.0)
         $error("skt_iter: control point must be strictly inside (0,1)");
      if (ZERO_SEED == '0)
         $error("skt_iter: ZERO_SEED must be nonzero");
   endgenerate

   skt_branch_e        br;
   logic [STATE_W-1:0] operand;
   logic [RW-1:0]      recip;
   logic [STATE_W-1:0] next_s;

   skt_branch #(
      .STATE_W (STATE_W),
      .P_Q     (P_Q)
   ) branch_i (
      .cur     (state_q),
      .br      (br),
      .operand (operand)
   );

   assign recip = (br == BR_STRETCH) ? R_LO : R_HI;

   skt_scale #(
      .STATE_W   (STATE_W),
      .FRAC_R    (FRAC_R),
      .ZERO_SEED (ZERO_SEED)
   ) scale_i (
      .operand (operand),
      .recip   (recip),
      .result  (next_s)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= RESET_STATE;
         ks_valid <= 1'b0;
      end else if (key_load) begin
         state_q  <= key_val;
         ks_valid <= 1'b0;
      end else begin
         if (step_en)
            state_q <= next_s;
         ks_valid <= step_en;
      end
   end

   assign ks_byte = state_q[KS_LSB +: 8];
endmodule

// File: rtl/skt_iter_chk.sv
module skt_iter_chk #(
   parameter int STATE_W = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               key_load,
   input logic [STATE_W-1:0] key_val,
   input logic               step_en,
   input logic [STATE_W-1:0] state_q,
   input logic               ks_valid
);
   // R2
   load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      key_load |=> (state_q == $past(key_val)) && !ks_valid);

   // R7
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!key_load && !step_en) |=> $stable(state_q) && !ks_valid);

   // R8
   valid_after_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !key_load) |=> ks_valid);

   // R6
   never_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !key_load) |=> (state_q != '0));
endmodule

bind skt_iter skt_iter_chk #(.STATE_W(STATE_W)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .key_load (key_load),
   .key_val  (key_val),
   .step_en  (step_en),
   .state_q  (state_q),
   .ks_valid (ks_valid)
);

// File: tb/skt_iter_tb_top.sv
module skt_iter_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   int n_vec = 0;
   int n_bad = 0;

   // main copy, p = 0.54321
   logic        a_load = 1'b0, a_en = 1'b0;
   logic [31:0] a_key  = '0;
   logic [31:0] a_state;
   logic [7:0]  a_byte;
   logic        a_valid;

   // second copy, p = 0.5
   logic        h_load = 1'b0, h_en = 1'b0;
   logic [31:0] h_key  = '0;
   logic [31:0] h_state;
   logic [7:0]  h_byte;
   logic        h_valid;

   skt_iter dut_i (
      .clk(clk), .rst_n(rst_n), .key_load(a_load), .key_val(a_key),
      .step_en(a_en), .state_q(a_state), .ks_byte(a_byte), .ks_valid(a_valid)
   );

   skt_iter #(.P_CTRL(0.5)) dut_h (
      .clk(clk), .rst_n(rst_n), .key_load(h_load), .key_val(h_key),
      .step_en(h_en), .state_q(h_state), .ks_byte(h_byte), .ks_valid(h_valid)
   );

   // constants computed from the requirements
   localparam longint PQ_A = longint'(0.54321 * 4294967296.0);
   localparam longint RL_A = longint'(1073741824.0 / 0.54321);
   localparam longint RH_A = longint'(1073741824.0 / (1.0 - 0.54321));

   function automatic logic [31:0] ref_step(logic [31:0] s);
      logic [63:0] op, pr;
      if ({32'd0, s} <= 64'(PQ_A)) begin
         op = {32'd0, s};
         pr = op * 64'(RL_A);
      end else begin
         op = 64'h1_0000_0000 - {32'd0, s};
         pr = op * 64'(RH_A);
      end
      if (pr[63:62] != 2'b00) return 32'hFFFF_FFFF;
      if (pr[61:30] == 32'd0) return 32'd1;
      return pr[61:30];
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic a_loadkey(logic [31:0] k, logic en);
      @(negedge clk);
      a_load = 1'b1; a_key = k; a_en = en;
      @(negedge clk);
      a_load = 1'b0; a_en = 1'b0;
   endtask

   task automatic a_step;
      @(negedge clk);
      a_en = 1'b1;
      @(negedge clk);
      a_en = 1'b0;
   endtask

   task automatic h_loadkey(logic [31:0] k);
      @(negedge clk);
      h_load = 1'b1; h_key = k;
      @(negedge clk);
      h_load = 1'b0;
   endtask

   task automatic h_step;
      @(negedge clk);
      h_en = 1'b1;
      @(negedge clk);
      h_en = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1 state", a_state, 32'h1234_5678);
      chk("R1 valid", {31'd0, a_valid}, 32'd0);
   endtask

   task automatic t_load;
      a_loadkey(32'h2468_ACE0, 1'b0);
      chk("R2 state", a_state, 32'h2468_ACE0);
      chk("R2 valid", {31'd0, a_valid}, 32'd0);
      a_loadkey(32'h0BAD_F00D, 1'b1); // load wins over step
      chk("R2 priority", a_state, 32'h0BAD_F00D);
      chk("R2 priority valid", {31'd0, a_valid}, 32'd0);
   endtask

   task automatic t_stretch;
      a_loadkey(32'h3000_0000, 1'b0);
      a_step;
      chk("R3 low", a_state, ref_step(32'h3000_0000));
      a_loadkey(32'(PQ_A), 1'b0);
      a_step;
      chk("R3 equal", a_state, ref_step(32'(PQ_A)));
   endtask

   task automatic t_fold;
      a_loadkey(32'(PQ_A) + 32'd1, 1'b0);
      a_step;
      chk("R4 just above", a_state, ref_step(32'(PQ_A) + 32'd1));
      a_loadkey(32'hE000_0000, 1'b0);
      a_step;
      chk("R4 high", a_state, ref_step(32'hE000_0000));
      a_loadkey(32'hFFFF_FFFF, 1'b0);
      a_step;
      chk("R4 top", a_state, ref_step(32'hFFFF_FFFF));
   endtask

   task automatic t_saturate;
      h_loadkey(32'h8000_0000); // 0.5 * 2.0 = 1.0 exactly
      h_step;
      chk("R5 saturate", h_state, 32'hFFFF_FFFF);
      h_step; // fold: (2^32-(2^32-1)) * 2^31 -> 2
      chk("R4 half fold", h_state, 32'd2);
      h_loadkey(32'h8000_0001);
      h_step;
      chk("R4 half just above", h_state, 32'hFFFF_FFFE);
   endtask

   task automatic t_zero;
      a_loadkey(32'd0, 1'b0);
      a_step;
      chk("R6 seed", a_state, 32'd1);
      h_loadkey(32'd0);
      h_step;
      chk("R6 seed half", h_state, 32'd1);
   endtask

   task automatic t_hold;
      a_loadkey(32'h5A5A_1234, 1'b0);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk("R7 hold", a_state, 32'h5A5A_1234);
         chk("R7 valid", {31'd0, a_valid}, 32'd0);
      end
   endtask

   task automatic t_byte;
      logic [31:0] e;
      a_loadkey(32'h2ABC_DEF1, 1'b0);
      chk("R8 byte after load", {24'd0, a_byte}, 32'h0000_00BC);
      e = ref_step(32'h2ABC_DEF1);
      a_step;
      chk("R8 byte", {24'd0, a_byte}, {24'd0, e[23:16]});
      chk("R8 valid high", {31'd0, a_valid}, 32'd1);
      @(negedge clk);
      chk("R8 valid drops", {31'd0, a_valid}, 32'd0);
   endtask

   task automatic t_run;
      logic [31:0] e;
      e = 32'h1357_9BDF;
      a_loadkey(e, 1'b0);
      @(negedge clk);
      a_en = 1'b1;
      for (int i = 0; i < 24; i++) begin
         @(negedge clk);
         e = ref_step(e);
         chk("R9 run", a_state, e);
         chk("R9 valid", {31'd0, a_valid}, 32'd1);
      end
      a_en = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_load;
      t_stretch;
      t_fold;
      t_saturate;
      t_zero;
      t_hold;
      t_byte;
      t_run;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule